// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block conditions the second ALU operand in the same cycle it is consumed. It takes a 32-bit value and applies one of five bit movements. The movements are a left shift, a logical right shift, an arithmetic right shift, a rotate right, and a single-step rotate right that passes through the carry flag. Alongside the moved value it returns the carry that the flag logic should capture. That carry is the last bit pushed off the end, or the incoming flag when nothing moved.

The shift distance can come from a 5-bit field carried in the instruction or from the low byte of a register. In a separate immediate mode the block ignores the value input. It instead widens an 8-bit unsigned constant to 32 bits and rotates it right by twice a 4-bit rotate field. The block is purely combinational and holds no state.

Top module: `opnd_shifter`

## Requirements
- R1: With `sh_kind` = 0 (or any of the unused codes 5 to 7) and a distance n from 1 to 31, `op_out` is `src_val` shifted left by n with zeros entering, and `c_out` is `src_val[32-n]`. A left shift by 4 therefore equals multiplication by 16 modulo 2^32.
- R2: With `sh_kind` = 1 and n from 1 to 31, `op_out` is `src_val` shifted right by n with zeros entering, and `c_out` is `src_val[n-1]`.
- R3: With `sh_kind` = 2 and n from 1 to 31, `op_out` is `src_val` shifted right by n with copies of bit 31 entering, and `c_out` is `src_val[n-1]`.
- R4: With `sh_kind` = 3 and nonzero n, `op_out` is `src_val` rotated right by n mod 32, and `c_out` equals `op_out[31]`. A nonzero multiple of 32 leaves the value unchanged and gives `c_out` = `src_val[31]`.
- R5: With `sh_kind` = 4, `op_out` = {`c_in`, `src_val[31:1]`} and `c_out` = `src_val[0]`, whatever the distance inputs hold.
- R6: Outside immediate mode and for codes other than 4, a distance of zero gives `op_out` = `src_val` and `c_out` = `c_in`.
- R7: A register distance of exactly 32 gives zero for codes 0 and 1, with `c_out` equal to `src_val[0]` for code 0 and `src_val[31]` for code 1. A distance above 32 gives zero and `c_out` = 0 for those codes. For code 2, any distance of 32 or more gives 32 copies of bit 31 and `c_out` equal to bit 31.
- R8: When `imm_en` = 1, `op_out` is {24 zeros, `imm_byte`} rotated right by 2×`imm_rot`. `c_out` is `c_in` when `imm_rot` = 0 and `op_out[31]` otherwise. In this mode `src_val`, `sh_kind` and both distance inputs have no effect.
- R9: The distance is `sh_reg` (8 bits) when `use_reg_amt` = 1 and `sh_imm` (5 bits) when it is 0. The unselected distance input has no effect on the outputs.
- R10: The outputs follow the inputs combinationally, within the same cycle and without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Value to be shifted or rotated |
| sh_kind | input | 3 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate-through-carry |
| sh_imm | input | 5 | Distance taken from the instruction |
| sh_reg | input | 8 | Distance taken from a register's low byte |
| use_reg_amt | input | 1 | Selects `sh_reg` over `sh_imm` |
| c_in | input | 1 | Current carry flag |
| imm_en | input | 1 | Selects the rotated-constant form |
| imm_byte | input | 8 | Unsigned constant for the immediate form |
| imm_rot | input | 4 | Half of the constant's rotate distance |
| op_out | output | 32 | Conditioned operand |
| c_out | output | 1 | Shifter carry for the flag logic |

## Verification
The bench targets the distance boundaries: zero, 1, 31, 32, 33 and large register values. It also covers rotate distances that are nonzero multiples of 32, and the zero-rotate immediate. A design that clamped the distance without special-casing 32 would return the wrong carry at exactly 32. A design that took rotate-by-32 as "no move" would hand back the incoming flag instead of bit 31. The bench also checks the rotate-through-carry: a design that rotated plain bit 0 around would lose the flag that should enter bit 31. It also confirms that the unselected distance input and the ignored value input in immediate mode leave the outputs unchanged. A reference model that moves one bit at a time checks a broad sweep of random vectors.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W      = 32,
  parameter int SIMM_W = 5,
  parameter int SREG_W = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [W-1:0]      src_val,
  input  logic [2:0]        sh_kind,
  input  logic [SIMM_W-1:0] sh_imm,
  input  logic [SREG_W-1:0] sh_reg,
  input  logic              use_reg_amt,
  input  logic              c_in,
  input  logic              imm_en,
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  output logic [W-1:0]      op_out,
  output logic              c_out
);
  localparam int AW = $clog2(W);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [SREG_W-1:0] amt, amt_cl;
  logic [AW-1:0]     rot_n, irot_n;
  logic [W:0]        lsl_t, lsr_t;
  logic signed [W:0] asr_t;
  logic [W-1:0]      ror_v, imm_ext, imm_v;

  assign amt    = use_reg_amt ? sh_reg : SREG_W'(sh_imm);
  assign amt_cl = (amt > SREG_W'(W)) ? SREG_W'(W) : amt;
  assign rot_n  = amt[AW-1:0];
  assign irot_n = AW'({imm_rot, 1'b0});

  assign lsl_t   = {1'b0, src_val} << amt;
  assign lsr_t   = {src_val, 1'b0} >> amt;
  assign asr_t   = $signed({src_val, 1'b0}) >>> amt_cl;
  assign ror_v   = W'({src_val, src_val} >> rot_n);
  assign imm_ext = {{(W-IMM_W){1'b0}}, imm_byte};
  assign imm_v   = W'({imm_ext, imm_ext} >> irot_n);

  always_comb begin
    op_out = src_val;
    c_out  = c_in;
    if (imm_en) begin
      op_out = imm_v;
      c_out  = (imm_rot == '0) ? c_in : imm_v[W-1];
    end else if (sh_kind == K_RRX) begin
      op_out = {c_in, src_val[W-1:1]};
      c_out  = src_val[0];
    end else if (amt != '0) begin
      case (sh_kind)
        K_LSR:   {op_out, c_out} = lsr_t;
        K_ASR:   {op_out, c_out} = asr_t;
        K_ROR: begin
          op_out = ror_v;
          c_out  = ror_v[W-1];
        end
        default: {c_out, op_out} = lsl_t;
      endcase
    end
  end

  always_comb begin
    // R6
    amt_zero_chk: assert (imm_en || sh_kind == K_RRX || amt != '0 ||
                          (op_out == src_val && c_out == c_in))
      else $error("zero distance altered operand");
    // R4
    ror_ones_chk: assert (imm_en || sh_kind != K_ROR ||
                          $countones(op_out) == $countones(src_val))
      else $error("rotate changed population count");
    // R7
    big_zero_chk: assert (imm_en || !(sh_kind == K_LSL || sh_kind == K_LSR) ||
                          amt <= SREG_W'(W) || (op_out == '0 && !c_out))
      else $error("oversized logical shift not zero");
    // R3
    asr_sign_chk: assert (imm_en || sh_kind != K_ASR || op_out[W-1] == src_val[W-1])
      else $error("arithmetic shift lost sign");
    // R8
    imm_ones_chk: assert (!imm_en || ($countones(op_out) == $countones(imm_byte) &&
                          c_out == ((imm_rot == '0) ? c_in : op_out[W-1])))
      else $error("immediate form malformed");
    // R5
    rrx_carry_chk: assert (imm_en || sh_kind != K_RRX ||
                           (op_out[W-1] == c_in && c_out == src_val[0]))
      else $error("rotate-through-carry wrong");
  end
endmodule

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] src_val;
  logic [2:0]  sh_kind;
  logic [4:0]  sh_imm;
  logic [7:0]  sh_reg;
  logic        use_reg_amt, c_in, imm_en;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [31:0] op_out;
  logic        c_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  opnd_shifter u0 (
    .src_val(src_val), .sh_kind(sh_kind), .sh_imm(sh_imm), .sh_reg(sh_reg),
    .use_reg_amt(use_reg_amt), .c_in(c_in), .imm_en(imm_en),
    .imm_byte(imm_byte), .imm_rot(imm_rot), .op_out(op_out), .c_out(c_out)
  );

  function automatic logic [32:0] model(input logic [31:0] v, input logic [2:0] k,
                                        input int n, input logic ci);
    logic [31:0] x = v;
    logic c = ci;
    if (k == 3'd4) return {v[0], ci, v[31:1]};
    for (int i = 0; i < n; i++) begin
      case (k)
        3'd1: begin c = x[0];  x = {1'b0, x[31:1]}; end
        3'd2: begin c = x[0];  x = {x[31], x[31:1]}; end
        3'd3: begin c = x[0];  x = {x[0], x[31:1]}; end
        default: begin c = x[31]; x = {x[30:0], 1'b0}; end
      endcase
    end
    return {c, x};
  endfunction

  function automatic logic [32:0] imodel(input logic [7:0] b, input logic [3:0] r,
                                         input logic ci);
    logic [31:0] x = {24'd0, b};
    logic c = ci;
    for (int i = 0; i < 2 * r; i++) begin
      c = x[0];
      x = {x[0], x[31:1]};
    end
    return {c, x};
  endfunction

  task automatic check(input string req, input logic [32:0] exp);
    n_chk++;
    if ({c_out, op_out} !== exp) begin
      n_bad++;
      $display("FAIL %s: got c=%0b v=%08h, expected c=%0b v=%08h",
               req, c_out, op_out, exp[32], exp[31:0]);
    end
  endtask

  task automatic apply_sh(input logic [31:0] v, input logic [2:0] k, input logic ureg,
                          input logic [4:0] si, input logic [7:0] sr, input logic ci);
    @(negedge clk);
    imm_en = 1'b0; src_val = v; sh_kind = k; use_reg_amt = ureg;
    sh_imm = si; sh_reg = sr; c_in = ci;
    #1;
  endtask

  task automatic run_sh(input string req, input logic [31:0] v, input logic [2:0] k,
                        input logic ureg, input logic [4:0] si, input logic [7:0] sr,
                        input logic ci);
    apply_sh(v, k, ureg, si, sr, ci);
    check(req, model(v, k, ureg ? int'(sr) : int'(si), ci));
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R6 idle", 33'd0);
  endtask

  task automatic t_lsl;
    run_sh("R1", 32'h8000_0001, 3'd0, 1'b0, 5'd1, 8'd0, 1'b0);
    run_sh("R1", 32'h0000_0003, 3'd0, 1'b0, 5'd4, 8'd0, 1'b0);
    check("R1 x16", {1'b0, 32'h0000_0030});
    run_sh("R1", 32'h0000_0001, 3'd0, 1'b0, 5'd31, 8'd0, 1'b1);
    run_sh("R1 code7", 32'hF000_000F, 3'd7, 1'b0, 5'd2, 8'd0, 1'b0);
  endtask

  task automatic t_lsr;
    run_sh("R2", 32'h8000_0001, 3'd1, 1'b0, 5'd1, 8'd0, 1'b0);
    run_sh("R2", 32'hF0F0_0080, 3'd1, 1'b0, 5'd8, 8'd0, 1'b1);
    check("R2 known", {1'b1, 32'h00F0_F000});
  endtask

  task automatic t_asr;
    run_sh("R3", 32'h8000_0010, 3'd2, 1'b0, 5'd4, 8'd0, 1'b1);
    check("R3 known", {1'b0, 32'hF800_0001});
    run_sh("R3", 32'h4000_0001, 3'd2, 1'b0, 5'd31, 8'd0, 1'b0);
  endtask

  task automatic t_ror;
    run_sh("R4", 32'h0000_0001, 3'd3, 1'b0, 5'd1, 8'd0, 1'b0);
    check("R4 known", {1'b1, 32'h8000_0000});
    run_sh("R4 mod32", 32'h1234_5678, 3'd3, 1'b1, 5'd0, 8'd36, 1'b0);
    run_sh("R4 x32", 32'h8000_0000, 3'd3, 1'b1, 5'd0, 8'd64, 1'b0);
    check("R4 x32 known", {1'b1, 32'h8000_0000});
  endtask

  task automatic t_rrx;
    run_sh("R5", 32'h0000_0003, 3'd4, 1'b0, 5'd9, 8'd0, 1'b1);
    check("R5 known", {1'b1, 32'h8000_0001});
    run_sh("R5", 32'h8000_0000, 3'd4, 1'b1, 5'd0, 8'd77, 1'b0);
  endtask

  task automatic t_zero;
    for (int k = 0; k < 4; k++) begin
      run_sh("R6", 32'hCAFE_1234, 3'(k), 1'b0, 5'd0, 8'd0, 1'b1);
      check("R6 pass", {1'b1, 32'hCAFE_1234});
    end
  endtask

  task automatic t_big;
    run_sh("R7 lsl32", 32'h0000_0001, 3'd0, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R7 lsl32 known", {1'b1, 32'd0});
    run_sh("R7 lsr32", 32'h8000_0000, 3'd1, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R7 lsr32 known", {1'b1, 32'd0});
    run_sh("R7 lsl33", 32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0, 8'd33, 1'b1);
    check("R7 lsl33 known", {1'b0, 32'd0});
    run_sh("R7 lsr200", 32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0, 8'd200, 1'b1);
    run_sh("R7 asr255", 32'h8000_0000, 3'd2, 1'b1, 5'd0, 8'd255, 1'b0);
    check("R7 asr known", {1'b1, 32'hFFFF_FFFF});
    run_sh("R7 asr32 pos", 32'h7FFF_FFFF, 3'd2, 1'b1, 5'd0, 8'd32, 1'b1);
  endtask

  task automatic t_imm;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      imm_en = 1'b1; imm_byte = 8'hA5; imm_rot = 4'(r); c_in = r[0];
      src_val = 32'hDEAD_BEEF; sh_kind = 3'(r % 5); sh_reg = 8'(r * 7); sh_imm = 5'(r);
      #1;
      check("R8", imodel(8'hA5, 4'(r), r[0]));
    end
    @(negedge clk);
    imm_byte = 8'h3F; imm_rot = 4'd1; c_in = 1'b0; #1;
    check("R8 known", {1'b1, 32'hC000_000F});
  endtask

  task automatic t_sel;
    apply_sh(32'h0000_00F0, 3'd1, 1'b0, 5'd4, 8'd0, 1'b0);
    check("R9 imm sel", {1'b0, 32'h0000_000F});
    sh_reg = 8'd200; #1;
    check("R9 reg ignored", {1'b0, 32'h0000_000F});
    apply_sh(32'h0000_00F0, 3'd1, 1'b1, 5'd31, 8'd5, 1'b0);
    check("R9 reg sel", {1'b1, 32'h0000_0007});
    sh_imm = 5'd3; #1;
    check("R9 imm ignored", {1'b1, 32'h0000_0007});
  endtask

  task automatic t_comb;
    apply_sh(32'h0000_0001, 3'd0, 1'b0, 5'd2, 8'd0, 1'b0);
    @(posedge clk);
    #0.5 src_val = 32'h0000_0002;
    #0.5 check("R10 no clock", {1'b0, 32'h0000_0008});
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v = $urandom;
      logic [2:0] k = 3'($urandom % 8);
      logic ur = 1'($urandom);
      logic [4:0] si = 5'($urandom);
      logic [7:0] sr = (i % 3 == 0) ? 8'($urandom % 70) : 8'($urandom);
      run_sh("R1-sweep R2 R3 R4 R5", v, k, ur, si, sr, 1'($urandom));
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    src_val = '0; sh_kind = '0; sh_imm = '0; sh_reg = '0; use_reg_amt = 1'b0;
    c_in = 1'b0; imm_en = 1'b0; imm_byte = '0; imm_rot = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset; t_lsl; t_lsr; t_asr; t_ror; t_rrx; t_zero; t_big; t_imm; t_sel; t_comb; t_sweep;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run;
    end
  end
endmodule